// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block sits between a clocked user port and an asynchronous 16-bit static RAM with two byte lanes. Each accepted request is a single word access. The controller turns it into the chip-enable, output-enable, write-enable and byte-select sequence the memory needs. The read data, or the completion of a write, is returned with a one-clock acknowledge.

Every phase length is a whole number of clocks. It is derived from a nanosecond minimum and a clock-period parameter by rounding up, with a floor of one clock. Writes always close on the rising edge of write enable. Write data is driven for the whole write pulse, and the data drivers switch on only after output enable has been high for the turnaround phase. The user holds the request high until the acknowledge is seen. A new request is taken only from the idle state.

Top module: `sram_strobe_ctl`

## Requirements
- R1: While and after reset, chip enable, output enable, write enable and both byte selects are high, the data drivers are off and acknowledge is low.
- R2: A write updates only the lanes whose byte enable is set: bit 0 selects data bits 7:0 through `memByteSelN[0]`, and bit 1 selects bits 15:8 through `memByteSelN[1]`. The other lane keeps its stored value.
- R3: A read returns the stored word on `rdData` in the cycle where `ack` is high.
- R4: Write enable goes low only while chip enable is low, output enable is high and the controller drives the bus. The data stays driven for at least the data-setup time before write enable rises, and that rise ends the write.
- R5: Output enable is high for at least the turnaround time before write enable falls. The controller never drives the bus while output enable is low, so it never drives while the memory drives.
- R6: The data drivers switch off in the clock after the one in which write enable rises.
- R7: A write with both byte enables clear is acknowledged without write enable or chip enable going low, and memory is unchanged.
- R8: `ack` is a single-clock pulse. Measured in clocks from the accepting edge, write latency is turnaround + pulse + 2, read latency is access + 1, and an empty write takes 1.
- R9: Each phase count is the ceiling of its nanosecond minimum divided by the clock period, at least 1. The write pulse also covers the address-valid-to-end time and the full write cycle time.
- R10: The memory address stays stable for as long as chip enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request, held until ack |
| wrEn | input | 1 | 1 = write, 0 = read |
| addr | input | 20 | Word address |
| wrData | input | 16 | Write data |
| byteEn | input | 2 | Lane enables for writes |
| ack | output | 1 | One-clock completion pulse |
| rdData | output | 16 | Read data, valid with ack |
| memAddr | output | 20 | Memory address bus |
| memCeN | output | 1 | Chip enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memByteSelN | output | 2 | Byte selects, active low (bit 0 low lane) |
| memDqOut | output | 16 | Data driven toward memory |
| memDqOutEn | output | 1 | Drive enable for memDqOut |
| memDqIn | input | 16 | Data returned by memory |

## Verification
The bench attacks partial-lane writes followed by reads of the same word. A controller that swapped or ignored lanes would read back a merged value different from the reference. It also checks empty writes, which a faulty controller would turn into a strobe pulse or a corrupted word. A memory model watches every write window: it flags write enable falling before output enable has been high long enough, driving while the memory drives, and writes whose data was not held up to the closing edge. Acknowledge latency is counted per transaction, so a phase that is short or long by one clock shows up as a latency miscompare.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;
  localparam int LANES  = DATA_W / 8;

  function automatic int phaseCycles(input int ns, input int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  typedef enum logic [2:0] {
    ST_IDLE, ST_WSETUP, ST_WPULSE, ST_WHOLD, ST_READ, ST_ACK
  } ctlState_e;

  typedef struct packed {
    logic ceN;
    logic oeN;
    logic weN;
    logic laneWrite;
    logic laneRead;
    logic drive;
    logic load;
    logic capture;
  } strobe_t;
endpackage

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_strobe_pkg::*;
#(
  parameter int SETUP_CYC  = 1,
  parameter int PULSE_CYC  = 1,
  parameter int ACCESS_CYC = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic       wrEn,
  input  logic [LANES-1:0] byteEn,
  output strobe_t    stb,
  output logic       ack
);
  localparam int MAX_CYC = maxOf(maxOf(SETUP_CYC, PULSE_CYC), ACCESS_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  ctlState_e state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic ceNq, oeNq, weNq, laneWq, laneRq, driveq, ackq;
  logic ceNd, oeNd, weNd, laneWd, laneRd, drived, ackd;

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    case (state)
      ST_IDLE: if (req) begin
        if (wrEn) begin
          if (byteEn == '0) stateNext = ST_ACK;
          else begin
            stateNext = ST_WSETUP;
            cntNext   = CNT_W'(SETUP_CYC - 1);
          end
        end else begin
          stateNext = ST_READ;
          cntNext   = CNT_W'(ACCESS_CYC - 1);
        end
      end
      ST_WSETUP: if (cnt == '0) begin
        stateNext = ST_WPULSE;
        cntNext   = CNT_W'(PULSE_CYC - 1);
      end else cntNext = cnt - 1'b1;
      ST_WPULSE: if (cnt == '0) stateNext = ST_WHOLD;
                 else cntNext = cnt - 1'b1;
      ST_WHOLD:  stateNext = ST_ACK;
      ST_READ:   if (cnt == '0) stateNext = ST_ACK;
                 else cntNext = cnt - 1'b1;
      ST_ACK:    stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  // Pin strobes are decoded from the next state and registered.
  always_comb begin
    ceNd = 1'b1; oeNd = 1'b1; weNd = 1'b1;
    laneWd = 1'b0; laneRd = 1'b0; drived = 1'b0; ackd = 1'b0;
    case (stateNext)
      ST_WSETUP: ceNd = 1'b0;
      ST_WPULSE: begin ceNd = 1'b0; weNd = 1'b0; laneWd = 1'b1; drived = 1'b1; end
      ST_WHOLD:  begin ceNd = 1'b0; laneWd = 1'b1; drived = 1'b1; end
      ST_READ:   begin ceNd = 1'b0; oeNd = 1'b0; laneRd = 1'b1; end
      ST_ACK:    ackd = 1'b1;
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; cnt <= '0;
      ceNq <= 1'b1; oeNq <= 1'b1; weNq <= 1'b1;
      laneWq <= 1'b0; laneRq <= 1'b0; driveq <= 1'b0; ackq <= 1'b0;
    end else begin
      state <= stateNext; cnt <= cntNext;
      ceNq <= ceNd; oeNq <= oeNd; weNq <= weNd;
      laneWq <= laneWd; laneRq <= laneRd; driveq <= drived; ackq <= ackd;
    end
  end

  assign stb.ceN       = ceNq;
  assign stb.oeN       = oeNq;
  assign stb.weN       = weNq;
  assign stb.laneWrite = laneWq;
  assign stb.laneRead  = laneRq;
  assign stb.drive     = driveq;
  assign stb.load      = (state == ST_IDLE) && req;
  assign stb.capture   = (state == ST_READ) && (cnt == '0);
  assign ack           = ackq;

  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
    !weNq |-> (!ceNq && oeNq)); // R4
  AST_WE_WITH_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !weNq |-> driveq); // R4
  AST_NO_DRIVE_WHILE_OE: assert property (@(posedge clk) disable iff (rst)
    driveq |-> oeNq); // R5
  AST_DRIVE_OFF_AFTER_WE: assert property (@(posedge clk) disable iff (rst)
    $rose(weNq) |=> !driveq); // R6
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    ackq |=> !ackq); // R8
endmodule

// File: rtl/sram_strobe_datapath.sv
module sram_strobe_datapath
  import sram_strobe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LANES-1:0]  byteEn,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANES-1:0]  memByteSelN,
  output logic [DATA_W-1:0] memDqOut,
  input  logic [DATA_W-1:0] memDqIn
);
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ, rdQ;
  logic [LANES-1:0]  laneQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ <= '0; dataQ <= '0; laneQ <= '0; rdQ <= '0;
    end else begin
      if (stb.load) begin
        addrQ <= addr; dataQ <= wrData; laneQ <= byteEn;
      end
      if (stb.capture) rdQ <= memDqIn;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign memByteSelN[g] = ~((stb.laneWrite && laneQ[g]) || stb.laneRead);
  end

  assign memAddr  = addrQ;
  assign memDqOut = dataQ;
  assign rdData   = rdQ;

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!stb.ceN && $past(!stb.ceN)) |-> $stable(memAddr)); // R10
endmodule

// File: rtl/sram_strobe_ctl.sv
module sram_strobe_ctl
  import sram_strobe_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 20,
  parameter int T_TURN_NS     = 4,
  parameter int T_WE_PULSE_NS = 8,
  parameter int T_DSETUP_NS   = 6,
  parameter int T_ADDR_END_NS = 8,
  parameter int T_WCYCLE_NS   = 10,
  parameter int T_ACCESS_NS   = 10,
  parameter int T_RCYCLE_NS   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LANES-1:0]  byteEn,
  output logic              ack,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [LANES-1:0]  memByteSelN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOutEn,
  input  logic [DATA_W-1:0] memDqIn
);
  // R9: phase lengths in clocks
  localparam int SETUP_CYC  = phaseCycles(T_TURN_NS, CLK_PERIOD_NS);
  localparam int PULSE_CYC  = maxOf(1, maxOf(
    maxOf(phaseCycles(T_WE_PULSE_NS, CLK_PERIOD_NS), phaseCycles(T_DSETUP_NS, CLK_PERIOD_NS)),
    maxOf(phaseCycles(T_ADDR_END_NS, CLK_PERIOD_NS) - SETUP_CYC,
          phaseCycles(T_WCYCLE_NS, CLK_PERIOD_NS) - SETUP_CYC - 1)));
  localparam int ACCESS_CYC = maxOf(phaseCycles(T_ACCESS_NS, CLK_PERIOD_NS),
                                    phaseCycles(T_RCYCLE_NS, CLK_PERIOD_NS));

  strobe_t stb;

  sram_strobe_ctrl #(
    .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .ACCESS_CYC(ACCESS_CYC)
  ) uCtrl (
    .clk(clk), .rst(rst), .req(req), .wrEn(wrEn), .byteEn(byteEn),
    .stb(stb), .ack(ack)
  );

  sram_strobe_datapath uData (
    .clk(clk), .rst(rst), .stb(stb), .addr(addr), .wrData(wrData),
    .byteEn(byteEn), .rdData(rdData), .memAddr(memAddr),
    .memByteSelN(memByteSelN), .memDqOut(memDqOut), .memDqIn(memDqIn)
  );

  assign memCeN     = stb.ceN;
  assign memOeN     = stb.oeN;
  assign memWeN     = stb.weN;
  assign memDqOutEn = stb.drive;
endmodule

// File: tb/sram_strobe_ctl_test.sv
module sram_strobe_ctl_test;
  localparam int PERIOD = 20;

  logic clk = 1'b0, rst = 1'b1;
  logic req = 1'b0, wrEn = 1'b0;
  logic [19:0] addr = '0;
  logic [15:0] wrData = '0;
  logic [1:0]  byteEn = '0;
  logic ack;
  logic [15:0] rdData, memDqOut;
  logic [19:0] memAddr;
  logic memCeN, memOeN, memWeN, memDqOutEn;
  logic [1:0] memByteSelN;
  logic [15:0] memDqIn = '0;

  int checks = 0, fails = 0;
  logic [15:0] model  [int unsigned];
  logic [15:0] refMem [int unsigned];

  always #(PERIOD/2) clk = ~clk;

  sram_strobe_ctl uut (
    .clk(clk), .rst(rst), .req(req), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .byteEn(byteEn), .ack(ack), .rdData(rdData), .memAddr(memAddr),
    .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN), .memByteSelN(memByteSelN),
    .memDqOut(memDqOut), .memDqOutEn(memDqOutEn), .memDqIn(memDqIn)
  );

  function automatic int ceilCyc(input int ns);
    int c = (ns + PERIOD - 1) / PERIOD;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  // R9: expected phase counts from the nanosecond minimums
  function automatic int turnCyc();  return ceilCyc(4); endfunction
  function automatic int pulseCyc();
    return mx(1, mx(mx(ceilCyc(8), ceilCyc(6)), mx(ceilCyc(8) - turnCyc(), ceilCyc(10) - turnCyc() - 1)));
  endfunction
  function automatic int accCyc(); return mx(ceilCyc(10), ceilCyc(10)); endfunction
  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d, input logic [1:0] be);
    return {be[1] ? d[15:8] : old[15:8], be[0] ? d[7:0] : old[7:0]};
  endfunction
  function automatic logic [15:0] refRead(input logic [19:0] a);
    return refMem.exists(a) ? refMem[a] : 16'h0000;
  endfunction

  task automatic check(input bit ok, input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  // Memory model and bus monitors (sampled at negedge)
  bit winPrev = 0, wePrevN = 1;
  int winCnt = 0, oeHighCnt = 0;
  logic [19:0] pAddr; logic [15:0] pData; logic [1:0] pSel; bit pDrive;
  always @(negedge clk) if (!rst) begin
    bit win, memDrives;
    win = !memCeN && !memWeN && (memByteSelN != 2'b11);
    memDrives = !memCeN && !memOeN && memWeN;
    if (memDqOutEn && memDrives) check(0, "R5 contention", 1, 0);
    if (!memWeN && wePrevN) check(oeHighCnt >= turnCyc(), "R5 turnaround", oeHighCnt, turnCyc());
    if (!memWeN) check(memDqOutEn == 1'b1, "R4 drive during pulse", memDqOutEn, 1);
    if (win) winCnt++;
    if (winPrev && !win) begin
      check(pDrive && winCnt * PERIOD >= 6, "R4 data setup", winCnt, pulseCyc());
      model[pAddr] = merge(model.exists(pAddr) ? model[pAddr] : 16'h0, pData, ~pSel);
      winCnt = 0;
    end
    if (!memCeN && memOeN) oeHighCnt++; else oeHighCnt = 0;
    winPrev = win; wePrevN = memWeN;
    pAddr = memAddr; pData = memDqOut; pSel = memByteSelN; pDrive = memDqOutEn;
    memDqIn <= memDrives ? (model.exists(memAddr) ? model[memAddr] : 16'h0) : 16'h0;
  end

  task automatic xact(input bit w, input logic [19:0] a, input logic [15:0] d, input logic [1:0] be);
    int lat = 0, expLat;
    int weLows = 0;
    @(negedge clk);
    req = 1; wrEn = w; addr = a; wrData = d; byteEn = be;
    expLat = !w ? accCyc() + 1 : (be == 2'b00 ? 1 : turnCyc() + pulseCyc() + 2);
    do begin
      @(negedge clk);
      lat++;
      if (!memWeN || !memCeN) weLows++;
    end while (!ack && lat < 50);
    check(lat == expLat, "R8 latency", lat, expLat);
    if (!w) check(rdData == refRead(a), "R3 read data", rdData, refRead(a));
    if (w && be == 2'b00) check(weLows == 0, "R7 no strobes", weLows, 0);
    if (w) refMem[a] = merge(refRead(a), d, be);
    req = 0;
    @(negedge clk);
    check(ack == 1'b0, "R8 ack pulse", ack, 0);
  endtask

  initial begin
    logic [19:0] pool [8];
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check({memCeN, memOeN, memWeN, memByteSelN} == 5'b11111, "R1 strobes in reset",
          {memCeN, memOeN, memWeN, memByteSelN}, 5'b11111);
    check(memDqOutEn == 1'b0 && ack == 1'b0, "R1 drivers/ack in reset", {memDqOutEn, ack}, 0);
    rst = 0;
    @(negedge clk);
    check({memCeN, memOeN, memWeN, memByteSelN, memDqOutEn} == 6'b111110, "R1 idle after reset",
          {memCeN, memOeN, memWeN, memByteSelN, memDqOutEn}, 6'b111110);
    // Directed corner cases
    xact(0, 20'h00010, 16'h0, 2'b00);            // R3 unwritten word reads 0
    xact(1, 20'h00010, 16'hA5C3, 2'b11);         // R2 full word
    xact(0, 20'h00010, 16'h0, 2'b00);
    xact(1, 20'h00010, 16'h1234, 2'b01);         // R2 low lane only
    xact(0, 20'h00010, 16'h0, 2'b00);
    xact(1, 20'h00010, 16'h5678, 2'b10);         // R2 high lane only
    xact(0, 20'h00010, 16'h0, 2'b00);
    xact(1, 20'h00010, 16'hFFFF, 2'b00);         // R7 empty write
    xact(0, 20'h00010, 16'h0, 2'b00);
    xact(1, 20'hFFFFF, 16'hBEEF, 2'b11);         // top address
    xact(0, 20'hFFFFF, 16'h0, 2'b00);
    // Constrained random mix over a small address pool
    foreach (pool[i]) pool[i] = 20'($urandom());
    for (int n = 0; n < 300; n++) begin
      int k = $urandom_range(0, 7);
      bit w = $urandom_range(0, 1);
      xact(w, pool[k], 16'($urandom()), 2'($urandom()));
    end
    foreach (pool[i]) xact(0, pool[i], 16'h0, 2'b00);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule